// File: doc/BRIEF.md
# SDRAM Bank Window Decoder

This block holds one configuration word for each SDRAM bank and resolves each physical address to the bank that owns it. Software programs the words over a small register port. Each word carries three things: a bank base aligned to 8 MiB, a size code and an enable bit. Stored values pass through a fixed keep-mask, so any bit outside that mask always reads as zero.

A lookup presents a 32-bit address with a valid strobe. One clock later the block returns a hit flag, the index of the owning bank and the offset of the address inside that bank's window. When windows overlap, the bank with the lowest index wins. A separate side port gives the byte size of any bank. Software uses it to read back the decoded capacity. The size is computed from the stored word and not from what was written.

Top module: `sdram_bank_decoder`

## Requirements
- R1: After reset every bank word reads as zero, and every lookup misses.
- R2: Bank n sits at register address 0x40+n. A read from any other register address returns zero, and a write there changes no bank word.
- R3: A write stores only the bits set in the keep-mask 0xFFDEE001. Every other bit of the word reads back as zero.
- R4: The size readback of a bank is (1024 − F) × 8 MiB, where F is bits 15:6 of the stored word. The result is 34 bits wide.
- R5: A bank's window starts at the stored bits 31:23 shifted left by 23 and is masked to the bank size. An address hits an enabled bank when its address bits match that masked base.
- R6: When several enabled windows contain the address, the result names the lowest bank index.
- R7: Each lookup gives exactly one result, on the clock after it is presented. A hit returns the offset of the address from the window start. A miss returns hit low, bank 0 and offset 0.
- R8: A bank with bit 0 clear never hits. This also holds on the cycle right after a write that clears its enable.
- R9: A lookup in the same cycle as a bank write is decoded with the old word. The new word applies from the next cycle.
- R10: A size field of zero makes the window span the whole 32-bit address space, so every address hits that bank if it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| look_valid | input | 1 | Lookup strobe |
| look_addr | input | 32 | Physical address to decode |
| res_valid | output | 1 | Result valid, one cycle after look_valid |
| res_hit | output | 1 | Address fell in an enabled window |
| res_bank | output | 2 | Owning bank index |
| res_offset | output | 32 | Offset of the address inside the window |
| size_sel | input | 2 | Bank chosen for size readback |
| size_bytes | output | 34 | Byte size of the selected bank |

## Verification
The bench writes an all-ones word. If the keep-mask is wrong or missing, the readback and the decoded size are both wrong, and every later window is mis-sized. It stacks identical windows, then disables the lower one. A priority encoder that favours the high index fails here, and so does a matcher that ignores the enable. It issues a lookup in the same cycle as the write that disables a bank: a bypassed write path would report a miss where the old word still owns the address. A zero size field and a 2 GiB window check the mask arithmetic at both extremes. A bad size computation shows up as a wrong offset or a spurious miss.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FIELD_LO = 6;
  localparam int unsigned FIELD_W  = 10;
  localparam int unsigned BASE_LO  = 23;
  localparam int unsigned SIZE_W   = 34;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SIZE_W-1:0] bytes_t;

  // Number of 8 MiB units covered by a stored bank word.
  function automatic logic [FIELD_W:0] units_of(word_t w);
    return (FIELD_W+1)'(1 << FIELD_W) - {1'b0, w[FIELD_LO +: FIELD_W]};
  endfunction

  function automatic bytes_t bank_bytes(word_t w);
    return bytes_t'(units_of(w)) << BASE_LO;
  endfunction

  // Address bits that must match the base; zero means whole space.
  function automatic word_t window_mask(word_t w);
    bytes_t span_m1;
    span_m1 = bank_bytes(w) - bytes_t'(1);
    return ~span_m1[WORD_W-1:0];
  endfunction

  function automatic word_t base_of(word_t w);
    return {w[WORD_W-1:BASE_LO], {BASE_LO{1'b0}}};
  endfunction

endpackage

// File: rtl/sbw_regs.sv
module sbw_regs
  import sbw_pkg::*;
#(
  parameter int unsigned NB        = 4,
  parameter int unsigned RA_W      = 10,
  parameter logic [RA_W-1:0] FIRST = 10'h040,
  parameter word_t KEEP            = 32'hFFDEE001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RA_W-1:0]      addr,
  input  word_t                wdata,
  output word_t                rdata,
  output logic [NB-1:0][WORD_W-1:0] banks
);

  logic [NB-1:0] sel;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign sel[g] = we && (addr == RA_W'(FIRST + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) banks[g] <= '0;
      else if (sel[g]) banks[g] <= wdata & KEEP;
    end

    p_untouched_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sel[g]) |-> $stable(banks[g]))
      else $error("bank %0d changed without a write", g);

    p_reset_clear_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> banks[g] == '0)
      else $error("bank %0d not cleared by reset", g);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NB; i++)
      if (addr == RA_W'(FIRST + i)) rdata = banks[i];
  end

endmodule

// File: rtl/sbw_match.sv
module sbw_match
  import sbw_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic [NB-1:0][WORD_W-1:0] banks,
  input  word_t                     addr,
  output logic [NB-1:0]             hit_vec,
  output logic [NB-1:0][WORD_W-1:0] offs
);

  for (genvar g = 0; g < NB; g++) begin : g_win
    word_t msk;
    assign msk        = window_mask(banks[g]);
    assign hit_vec[g] = banks[g][0] && ((addr & msk) == (base_of(banks[g]) & msk));
    assign offs[g]    = addr & ~msk;
  end

endmodule

// File: rtl/sbw_pick.sv
module sbw_pick
  import sbw_pkg::*;
#(
  parameter int unsigned NB   = 4,
  parameter int unsigned BI_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      look_valid,
  input  logic [NB-1:0]             hit_vec,
  input  logic [NB-1:0][WORD_W-1:0] offs,
  output logic                      res_valid,
  output logic                      res_hit,
  output logic [BI_W-1:0]           res_bank,
  output word_t                     res_offset
);

  logic [BI_W-1:0] win_idx;
  logic            any_hit;

  assign any_hit = |hit_vec;

  always_comb begin
    win_idx = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (hit_vec[i]) win_idx = BI_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_bank   <= '0;
      res_offset <= '0;
    end else begin
      res_valid <= look_valid;
      if (look_valid && any_hit) begin
        res_hit    <= 1'b1;
        res_bank   <= win_idx;
        res_offset <= offs[win_idx];
      end else begin
        res_hit    <= 1'b0;
        res_bank   <= '0;
        res_offset <= '0;
      end
    end
  end

  p_latency_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(look_valid))
    else $error("result without a lookup");

  p_miss_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_bank == '0 && res_offset == '0))
    else $error("miss with nonzero bank or offset");

  p_lowest_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |->
      ((($past(hit_vec) >> res_bank) & NB'(1)) != '0 &&
       ($past(hit_vec) & ((NB'(1) << res_bank) - NB'(1))) == '0))
    else $error("winner is not the lowest hitting bank");

endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
  import sbw_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned RA_W        = 10,
  parameter logic [RA_W-1:0] FIRST_REG = 10'h040,
  parameter logic [31:0] KEEP_MASK   = 32'hFFDEE001,
  localparam int unsigned BI_W       = $clog2(NUM_BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [RA_W-1:0] cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            look_valid,
  input  logic [31:0]     look_addr,
  output logic            res_valid,
  output logic            res_hit,
  output logic [BI_W-1:0] res_bank,
  output logic [31:0]     res_offset,
  input  logic [BI_W-1:0] size_sel,
  output logic [33:0]     size_bytes
);

  logic [NUM_BANKS-1:0][WORD_W-1:0] banks;
  logic [NUM_BANKS-1:0][WORD_W-1:0] offs;
  logic [NUM_BANKS-1:0]             hit_vec;
  logic [NUM_BANKS-1:0]             bank_en;

  sbw_regs #(.NB(NUM_BANKS), .RA_W(RA_W), .FIRST(FIRST_REG), .KEEP(KEEP_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .banks(banks)
  );

  sbw_match #(.NB(NUM_BANKS)) u_match (
    .banks(banks), .addr(look_addr), .hit_vec(hit_vec), .offs(offs)
  );

  sbw_pick #(.NB(NUM_BANKS), .BI_W(BI_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .look_valid(look_valid), .hit_vec(hit_vec),
    .offs(offs), .res_valid(res_valid), .res_hit(res_hit),
    .res_bank(res_bank), .res_offset(res_offset)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_en
    assign bank_en[g] = banks[g][0];
  end

  assign size_bytes = bank_bytes(banks[size_sel]);

  p_disabled_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> ((($past(bank_en) >> res_bank) & NUM_BANKS'(1)) != '0))
    else $error("hit reported on a disabled bank");

  p_no_hit_idle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hit)
    else $error("hit flag without result valid");

endmodule

// File: tb/sim_sdram_bank_decoder.sv
module sim_sdram_bank_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        look_valid = 1'b0;
  logic [31:0] look_addr = '0;
  logic        res_valid, res_hit;
  logic [1:0]  res_bank;
  logic [31:0] res_offset;
  logic [1:0]  size_sel = '0;
  logic [33:0] size_bytes;

  always #5 clk = ~clk;

  sdram_bank_decoder u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] shadow [4];
  logic [64:0] exp_q [$];
  string       tag_q [$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected result: window as a byte range [lo, lo+span).
  function automatic logic [64:0] model(logic [31:0] a);
    for (int n = 0; n < 4; n++) begin
      logic [63:0] span, lo;
      span = 64'(1024 - int'(shadow[n][15:6])) * 64'h80_0000;
      lo   = 64'(shadow[n][31:23]) << 23;
      lo   = lo - (lo % span);
      if (shadow[n][0] && 64'(a) >= lo && 64'(a) < lo + span)
        return {1'b1, 32'(n), 32'(64'(a) - lo)};
    end
    return '0;
  endfunction

  task automatic write_bank(int n, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10'h040 + 10'(n); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[n] = v & 32'hFFDEE001;
  endtask

  task automatic lookup(logic [31:0] a, string req);
    @(negedge clk);
    look_valid = 1'b1; look_addr = a;
    exp_q.push_back(model(a)); tag_q.push_back(req);
    @(negedge clk);
    look_valid = 1'b0;
  endtask

  task automatic read_reg(logic [9:0] ra, logic [31:0] exp, string req);
    @(negedge clk);
    cfg_addr = ra;
    #2 check(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic read_size(int n, logic [33:0] exp, string req);
    @(negedge clk);
    size_sel = 2'(n);
    #2 check(req, 64'(size_bytes), 64'(exp));
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7: unexpected result actual %b expected none", res_hit);
      end else begin
        logic [64:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, {31'b0, res_hit, 30'b0, res_bank}, {31'b0, e[64], e[63:32]});
        check(t, 64'(res_offset), 64'(e[31:0]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 4; i++) read_reg(10'h040 + 10'(i), 32'h0, "R1");
    lookup(32'h0000_1000, "R1");

    // R3: keep-mask on writes
    write_bank(0, 32'h0000_E001);
    read_reg(10'h040, 32'h0000_E001, "R3");
    write_bank(1, 32'hFFFF_FFFF);
    read_reg(10'h041, 32'hFFDE_E001, "R3");

    // R4: size readback
    read_size(1, 34'h0_4000_0000, "R4");
    read_size(2, 34'h2_0000_0000, "R4");

    // R5 / R7: hits and misses
    lookup(32'h1234_5678, "R5");
    lookup(32'hC000_0010, "R5");
    lookup(32'h8000_0000, "R7");

    // R6: overlapping windows
    write_bank(2, 32'h0000_E001);
    lookup(32'h0000_0100, "R6");

    // R8: disable lower bank
    write_bank(0, 32'h0000_E000);
    lookup(32'h0000_0100, "R8");

    // R9: write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10'h042; cfg_wdata = 32'h0;
    look_valid = 1'b1; look_addr = 32'h0000_0200;
    exp_q.push_back(model(32'h0000_0200)); tag_q.push_back("R9");
    @(negedge clk);
    cfg_we = 1'b0; look_valid = 1'b0;
    shadow[2] = '0;
    lookup(32'h0000_0200, "R8");

    // R10: zero size field covers everything
    write_bank(3, 32'h0000_0001);
    read_size(3, 34'h2_0000_0000, "R10");
    lookup(32'h8000_0000, "R10");
    lookup(32'hC000_0004, "R6");

    // 2 GiB window at upper half
    write_bank(0, 32'h8000_C001);
    read_size(0, 34'h0_8000_0000, "R4");
    lookup(32'h9000_0000, "R5");

    // R2: unmapped addresses
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10'h044; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    read_reg(10'h044, 32'h0, "R2");
    read_reg(10'h03F, 32'h0, "R2");
    read_reg(10'h043, 32'h0000_0001, "R2");

    // back-to-back stream
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      look_valid = 1'b1; look_addr = 32'h2000_0000 * 32'(k) + 32'h40;
      exp_q.push_back(model(look_addr)); tag_q.push_back("R7");
      @(negedge clk);
    end
    look_valid = 1'b0;

    repeat (4) @(negedge clk);
    check("R7", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule